// File: doc/BRIEF.md
# Programmable SD Card Clock Generator

This block derives the SD card clock from a faster base clock. A select value N, built from an 8-bit low field and a separate 2-bit upper field, gives a card clock of the base clock divided by 2N with equal high and low phases. A select of zero passes the base clock straight through, gated without glitches. An internal clock enable starts a settle timer, and the card clock cannot start until that timer reports the clock as stable.

The card clock always stops at a low level. When the SD clock enable is removed, the current high phase runs to its end, and then the output is held low. The select value is captured only while the clock is stopped, so the running frequency never changes in the middle of a burst. If the card is removed, the enable is cleared, and it stays cleared until software removes it and asserts it again. One-cycle rise and fall strobes in the base clock domain tell the command and data logic when the card clock has just changed level.

Top module: `sdclk_gen`

## Requirements
- R1: For a select N in 1..2^(LO_W+2)-1, every high phase and every low phase of `sdclk_o` lasts exactly N base clock cycles.
- R2: When the run condition is removed, `sdclk_o` finishes its current high phase at full length and then stays at 0. While stopped, `sdclk_o` is 0.
- R3: The select is captured only while the clock is stopped. A change to the select while the clock runs leaves the running half-period unchanged, and the new value applies after the next stop and restart.
- R4: `int_clk_stable_o` rises after exactly STABLE_CYC (default 8) base clock rising edges with `int_clk_en_i` high. `sdclk_o` does not start while it is low.
- R5: When `card_present_i` is low, the clock stops (at low level) and the enable is cleared. After the card returns, the clock stays off until `sd_clk_en_i` goes low and then high again.
- R6: The select value is {`div_hi_i`, `div_lo_i`}, with `div_hi_i` forming the two most significant bits.
- R7: `int_clk_stable_o` goes low in the same cycle that `int_clk_en_i` goes low, with no clock edge needed. A running card clock then stops at low level.
- R8: In divide mode, `rise_stb_o` is high for exactly the base cycle in which `sdclk_o` has just become 1, and `fall_stb_o` is high for exactly the base cycle in which it has just become 0. They are never high together.
- R9: With select 0, `sdclk_o` follows the base clock while running. The gate changes only on the base clock falling edge, both strobes are held high while the gate is open, and after the enable is removed `sdclk_o` stays 0.
- R10: With the clock stable and the card present, `sdclk_o` goes high on the second base clock rising edge after `sd_clk_en_i` rises. This first high phase has the full length N.
- R11: While reset is high, and directly after it, `sdclk_o`, both strobes and `int_clk_stable_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous active-high reset |
| int_clk_en_i | input | 1 | Internal clock enable, starts the settle timer |
| sd_clk_en_i | input | 1 | Card clock enable |
| div_lo_i | input | LO_W | Lower bits of the divider select |
| div_hi_i | input | 2 | Upper two bits of the divider select |
| card_present_i | input | 1 | Card inserted level |
| sdclk_o | output | 1 | Card clock |
| rise_stb_o | output | 1 | Card clock has just risen |
| fall_stb_o | output | 1 | Card clock has just fallen |
| int_clk_stable_o | output | 1 | Internal clock stable flag |

## Verification
The bench builds the block with LO_W=4, which makes the select 6 bits wide, and keeps STABLE_CYC at 8. At that width, every select value from 0 to 63 can be swept in a few thousand cycles. Each value goes through start latency, both phase lengths, strobe placement and the tail that ends at a low level, and the upper 2-bit field is exercised on every value. Separate runs cover a select change while the clock is running, card removal and re-arming, loss of the internal enable, and the gated path at select 0. In the gated path, the bench samples inside both halves of the base clock.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
  localparam int HI_W = 2;
  typedef enum logic [1:0] {CLK_IDLE, CLK_DIV, CLK_BYP} clk_mode_e;
endpackage

// File: rtl/sdclk_stable_timer.sv
`timescale 1ns/1ps
module sdclk_stable_timer #(
  parameter int STABLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic stable_o
);
  generate
    if (STABLE_CYC == 0) begin : g_none
      assign stable_o = en_i;
    end else begin : g_cnt
      localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;
      localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);
      logic [CW-1:0] cnt_q;
      logic          stable_q;

      always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
          cnt_q    <= '0;
          stable_q <= 1'b0;
        end else if (!stable_q) begin
          if (cnt_q == LAST) stable_q <= 1'b1;
          else               cnt_q    <= cnt_q + 1'b1;
        end
      end

      // clears in the same cycle the enable drops
      assign stable_o = stable_q & en_i;

      assert_stable_late_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(stable_q) |-> (cnt_q == LAST));
    end
  endgenerate
endmodule

// File: rtl/sdclk_enable_ctrl.sv
`timescale 1ns/1ps
module sdclk_enable_ctrl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sd_en_i,
  input  logic card_i,
  input  logic stable_i,
  output logic run_req_o
);
  logic en_d_q;
  logic arm_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_d_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      en_d_q <= sd_en_i;
      if (!card_i || !sd_en_i) arm_q <= 1'b0;
      else if (!en_d_q)        arm_q <= 1'b1;
    end
  end

  assign run_req_o = sd_en_i & card_i & arm_q & stable_i;

  assert_card_clear_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !card_i |=> !arm_q);
endmodule

// File: rtl/sdclk_div_core.sv
`timescale 1ns/1ps
module sdclk_div_core
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_req_i,
  input  logic [DIV_W-1:0] sel_i,
  output logic             sdclk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o,
  output logic             running_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic             running_q, sdclk_q, rise_q, fall_q, gate_n_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic             byp;
  clk_mode_e        mode;

  assign byp = (div_q == '0);

  always_comb begin
    if (!running_q) mode = CLK_IDLE;
    else if (byp)   mode = CLK_BYP;
    else            mode = CLK_DIV;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      running_q <= 1'b0;
      sdclk_q   <= 1'b0;
      rise_q    <= 1'b0;
      fall_q    <= 1'b0;
      div_q     <= '0;
      cnt_q     <= '0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      case (mode)
        CLK_IDLE: begin
          if (run_req_i) begin
            running_q <= 1'b1;
            cnt_q     <= '0;
            if (!byp) begin
              sdclk_q <= 1'b1;
              rise_q  <= 1'b1;
            end
          end else begin
            div_q <= sel_i;
          end
        end
        CLK_BYP: running_q <= run_req_i;
        default: begin
          if (!sdclk_q && !run_req_i) begin
            running_q <= 1'b0;
          end else if (cnt_q == (div_q - ONE)) begin
            cnt_q   <= '0;
            sdclk_q <= ~sdclk_q;
            rise_q  <= ~sdclk_q;
            fall_q  <= sdclk_q;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
      endcase
    end
  end

  // gate for the pass-through path changes while the base clock is low
  always_ff @(negedge clk_i) begin
    if (rst_i) gate_n_q <= 1'b0;
    else       gate_n_q <= (mode == CLK_BYP) && run_req_i;
  end

  assign sdclk_o    = sdclk_q | (gate_n_q & clk_i);
  assign rise_stb_o = rise_q | gate_n_q;
  assign fall_stb_o = fall_q | gate_n_q;
  assign running_o  = running_q;

  assert_idle_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !running_q |-> !sdclk_q);
  assert_hold_sel_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    running_q |-> $stable(div_q));
  assert_half_len_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (running_q && $past(running_q) && !$past(byp) && (sdclk_q != $past(sdclk_q)))
      |-> ($past(cnt_q) == ($past(div_q) - ONE)));
  assert_byp_quiet_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    gate_n_q |-> !sdclk_q);
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !gate_n_q |-> !(rise_stb_o && fall_stb_o));
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int LO_W       = 8,
  parameter int STABLE_CYC = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            int_clk_en_i,
  input  logic            sd_clk_en_i,
  input  logic [LO_W-1:0] div_lo_i,
  input  logic [1:0]      div_hi_i,
  input  logic            card_present_i,
  output logic            sdclk_o,
  output logic            rise_stb_o,
  output logic            fall_stb_o,
  output logic            int_clk_stable_o
);
  localparam int DIV_W = LO_W + HI_W;

  logic             stable_w, run_req_w, running_w;
  logic [DIV_W-1:0] sel_w;

  assign sel_w = {div_hi_i, div_lo_i};

  sdclk_stable_timer #(.STABLE_CYC(STABLE_CYC)) u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(int_clk_en_i), .stable_o(stable_w)
  );

  sdclk_enable_ctrl u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .sd_en_i(sd_clk_en_i), .card_i(card_present_i),
    .stable_i(stable_w), .run_req_o(run_req_w)
  );

  sdclk_div_core #(.DIV_W(DIV_W)) u_core (
    .clk_i(clk_i), .rst_i(rst_i), .run_req_i(run_req_w), .sel_i(sel_w),
    .sdclk_o(sdclk_o), .rise_stb_o(rise_stb_o), .fall_stb_o(fall_stb_o),
    .running_o(running_w)
  );

  assign int_clk_stable_o = stable_w;

  assert_start_stable_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(running_w) |-> $past(stable_w));
endmodule

// File: tb/sdclk_gen_tb.sv
`timescale 1ns/1ps
module sdclk_gen_tb_top;
  localparam int CLK_T = 10;
  localparam int LO_W  = 4;
  localparam int NMAX  = (1 << (LO_W + 2)) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic int_en = 1'b0, sd_en = 1'b0, card = 1'b1;
  logic [LO_W-1:0] dlo = '0;
  logic [1:0] dhi = '0;
  logic sdclk, rstb, fstb, stable;

  int checks = 0, fails = 0;
  logic prev = 1'b0;
  int stb_bad = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  sdclk_gen #(.LO_W(LO_W), .STABLE_CYC(8)) dut_i (
    .clk_i(clk), .rst_i(rst), .int_clk_en_i(int_en), .sd_clk_en_i(sd_en),
    .div_lo_i(dlo), .div_hi_i(dhi), .card_present_i(card),
    .sdclk_o(sdclk), .rise_stb_o(rstb), .fall_stb_o(fstb), .int_clk_stable_o(stable)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #(CLK_T/4);
  endtask

  // tick and track strobe placement against the sampled clock level
  task automatic tick_s();
    tick();
    if (rstb != (sdclk && !prev) || fstb != (!sdclk && prev)) stb_bad++;
    prev = sdclk;
  endtask

  task automatic phase(output int len);
    logic lvl;
    lvl = sdclk; len = 1; tick_s();
    while (sdclk == lvl && len < 400) begin len++; tick_s(); end
  endtask

  task automatic set_sel(input int n);
    dhi = 2'(n >> LO_W); dlo = LO_W'(n);
  endtask

  task automatic start_clk(input int n, input string req);
    set_sel(n); tick(); prev = 1'b0;
    sd_en = 1'b1; tick_s();
    check(sdclk == 1'b0, req, sdclk, 0);
    tick_s();
    check(sdclk == 1'b1 && rstb == 1'b1, req, sdclk, 1);
  endtask

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int h, l, cnt;
    repeat (4) tick();
    check(sdclk == 0 && rstb == 0 && fstb == 0 && stable == 0, "R11 in reset", sdclk, 0);
    rst = 1'b0; tick();
    check(sdclk == 0 && rstb == 0 && fstb == 0 && stable == 0, "R11 after reset", stable, 0);

    // enable without stable internal clock: no output
    set_sel(3); sd_en = 1'b1; cnt = 0;
    repeat (20) begin tick(); if (sdclk) cnt++; end
    check(cnt == 0, "R4 no run before stable", cnt, 0);
    int_en = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick();
      if (k == 7) check(stable == 0, "R4 stable at 7 edges", stable, 0);
      if (k == 8) check(stable == 1, "R4 stable at 8 edges", stable, 1);
    end
    tick(); tick();
    check(sdclk == 1, "R4 starts once stable", sdclk, 1);
    sd_en = 1'b0; repeat (12) tick();

    // sweep every select value
    for (int n = 1; n <= NMAX; n++) begin
      stb_bad = 0;
      start_clk(n, "R10 start latency");
      phase(h); phase(l);
      check(h == n, "R1 R6 high phase", h, n);
      check(l == n, "R1 R6 low phase", l, n);
      sd_en = 1'b0;
      phase(h);
      check(h == n, "R2 tail high full", h, n);
      cnt = 0;
      repeat (2 * n + 4) begin tick_s(); if (sdclk) cnt++; end
      check(cnt == 0, "R2 held low", cnt, 0);
      check(stb_bad == 0, "R8 strobes", stb_bad, 0);
    end

    // select change while running
    start_clk(4, "R10 start");
    set_sel(9);
    phase(h); phase(l); phase(h);
    check(l == 4 && h == 4, "R3 running freq held", h, 4);
    sd_en = 1'b0; repeat (20) tick();
    start_clk(9, "R10 restart");
    phase(h);
    check(h == 9, "R3 new freq after restart", h, 9);
    sd_en = 1'b0; repeat (30) tick();

    // explicit upper field: {01,0000} = 16
    dhi = 2'b01; dlo = '0; tick(); prev = 1'b0;
    sd_en = 1'b1; tick_s(); tick_s();
    phase(h);
    check(h == 16, "R6 upper field", h, 16);
    sd_en = 1'b0; repeat (40) tick();

    // card removal
    start_clk(2, "R10 start");
    card = 1'b0; repeat (6) tick(); cnt = 0;
    repeat (10) begin tick(); if (sdclk) cnt++; end
    check(cnt == 0, "R5 stops on removal", cnt, 0);
    card = 1'b1; cnt = 0;
    repeat (20) begin tick(); if (sdclk) cnt++; end
    check(cnt == 0, "R5 stays cleared", cnt, 0);
    sd_en = 1'b0; tick(); sd_en = 1'b1; tick(); tick();
    check(sdclk == 1, "R5 rearm", sdclk, 1);
    sd_en = 1'b0; repeat (10) tick();

    // loss of internal enable
    start_clk(3, "R10 start");
    int_en = 1'b0; #1;
    check(stable == 0, "R7 stable drops at once", stable, 0);
    repeat (5) tick(); cnt = 0;
    repeat (10) begin tick(); if (sdclk) cnt++; end
    check(cnt == 0, "R7 clock stops", cnt, 0);
    sd_en = 1'b0; int_en = 1'b1; repeat (12) tick();

    // pass-through mode
    set_sel(0); tick(); sd_en = 1'b1;
    repeat (5) tick();
    cnt = 0;
    repeat (6) begin
      @(posedge clk); #(CLK_T/4);
      if (sdclk != 1 || rstb != 1 || fstb != 1) cnt++;
      tick();
      if (sdclk != 0 || rstb != 1 || fstb != 1) cnt++;
    end
    check(cnt == 0, "R9 follows base clock", cnt, 0);
    sd_en = 1'b0; repeat (3) tick(); cnt = 0;
    repeat (6) begin
      @(posedge clk); #(CLK_T/4);
      if (sdclk || rstb || fstb) cnt++;
    end
    check(cnt == 0, "R9 stopped low", cnt, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule